// File: doc/BRIEF.md
# MII receive status sequencer

This block drives the receive-side status and data pins of a media-independent interface from a nibble stream produced inside a PHY. The line decoder supplies a data nibble together with start-of-packet, end-of-packet and per-nibble error strobes. The link monitor supplies a link-fail level. Clock recovery supplies a recovered flag, and the collision detector supplies a collision level. The block turns these into carrier sense, data valid, receive data, receive error and collision outputs. Every output is registered, so each one changes one receive-clock cycle after the strobes that cause it.

Carrier sense and data valid are sequenced separately. At 100 Mbps, data valid starts together with carrier sense. At 10 Mbps, carrier sense starts at packet start, but data valid waits until the recovered-clock flag arrives, and error reporting is disabled at that speed. While the link is failed, both carrier sense and data valid stay low whatever packet activity is seen.

Top module: `mii_rx_seq`

## Requirements
- R1: While rst_ni is low, crs_o, rxdv_o, rxer_o and col_o are 0 and rxd_o is all zeros.
- R2: When no packet is in progress, crs_o and rxdv_o are 0 and rxd_o is 0; rxd_o is 0 in every cycle where rxdv_o is 0.
- R3: With link_fail_i low, sop_i high and eop_i low in a cycle, crs_o is 1 from the next cycle. It stays 1 until a cycle with eop_i or link_fail_i high has passed. rxdv_o is never 1 while crs_o is 0.
- R4: With speed_100_i high, rxdv_o rises together with crs_o. In each cycle where rxdv_o is 1, rxd_o equals the nib_i of the previous cycle.
- R5: A cycle with eop_i high (and no link fail) makes crs_o, rxdv_o and rxd_o all 0 in the next cycle. The nibble presented with eop_i is not output.
- R6: A cycle with link_fail_i high makes crs_o and rxdv_o 0 and rxd_o zero in the next cycle, even when sop_i is high. Any packet in progress is dropped.
- R7: With speed_100_i high, rxer_o is 1 in exactly those cycles where rxdv_o is 1 and err_i was 1 on the previous cycle. It therefore marks only the one cycle in which the errored nibble is on rxd_o.
- R8: With speed_100_i low in the previous cycle, rxer_o is 0.
- R9: With speed_100_i low, rxdv_o stays 0 inside a packet until a cycle with clk_rec_i high. From the next cycle it is 1, and it stays 1 until the packet ends. Before that, rxd_o is 0.
- R10: col_o equals col_det_i of the previous cycle.
- R11: If sop_i and eop_i are high in the same cycle, end of packet wins. The next cycle has crs_o at 0, whether the block was idle or inside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | receive clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| nib_i | input | DATA_W | decoded data nibble |
| sop_i | input | 1 | start-of-packet strobe |
| eop_i | input | 1 | end-of-packet strobe |
| err_i | input | 1 | error flag for the current nibble |
| link_fail_i | input | 1 | link-fail level |
| speed_100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| clk_rec_i | input | 1 | recovered-clock indication (10 Mbps) |
| col_det_i | input | 1 | collision detected |
| rxd_o | output | DATA_W | receive data |
| crs_o | output | 1 | carrier sense |
| rxdv_o | output | 1 | receive data valid |
| rxer_o | output | 1 | receive error |
| col_o | output | 1 | collision |

## Verification
The bench builds the block with the default DATA_W of 4, which is the real MII data width. This covers every nibble value in the random stream. Strobe probabilities are biased so that back-to-back packets, start and end in the same cycle, link failure in mid-packet, and speed changes with and without clock recovery all occur many times. Directed sequences pin down the 10 Mbps valid delay and the end-wins priority.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int unsigned NIB_W = 4;
  typedef enum logic {CS_IDLE = 1'b0, CS_PKT = 1'b1} carrier_e;
endpackage

// File: rtl/mii_rx_carrier.sv
module mii_rx_carrier
  import mii_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic eop_i,
  input  logic link_fail_i,
  output logic pkt_nxt_o,
  output logic crs_o
);
  carrier_e state_q, state_d;

  // link fail dominates, then end, then start
  always_comb begin
    state_d = state_q;
    if (link_fail_i)  state_d = CS_IDLE;
    else if (eop_i)   state_d = CS_IDLE;
    else if (sop_i)   state_d = CS_PKT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CS_IDLE;
    else         state_q <= state_d;
  end

  assign pkt_nxt_o = (state_d == CS_PKT);
  assign crs_o     = (state_q == CS_PKT);
endmodule

// File: rtl/mii_rx_valid.sv
module mii_rx_valid #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_nxt_i,
  input  logic              speed_100_i,
  input  logic              clk_rec_i,
  input  logic [DATA_W-1:0] nib_i,
  input  logic              err_i,
  output logic              rxdv_o,
  output logic [DATA_W-1:0] rxd_o,
  output logic              rxer_o
);
  logic dv_d;

  // 10M: valid latches on recovery and holds for rest of packet
  assign dv_d = pkt_nxt_i & (speed_100_i | clk_rec_i | rxdv_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxdv_o <= 1'b0;
      rxd_o  <= '0;
      rxer_o <= 1'b0;
    end else begin
      rxdv_o <= dv_d;
      rxd_o  <= dv_d ? nib_i : '0;
      rxer_o <= dv_d & speed_100_i & err_i;
    end
  end
endmodule

// File: rtl/mii_rx_seq.sv
module mii_rx_seq
  import mii_rx_pkg::*;
#(
  parameter int unsigned DATA_W = NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] nib_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              err_i,
  input  logic              link_fail_i,
  input  logic              speed_100_i,
  input  logic              clk_rec_i,
  input  logic              col_det_i,
  output logic [DATA_W-1:0] rxd_o,
  output logic              crs_o,
  output logic              rxdv_o,
  output logic              rxer_o,
  output logic              col_o
);
  logic pkt_nxt;

  mii_rx_carrier u_carrier (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sop_i       (sop_i),
    .eop_i       (eop_i),
    .link_fail_i (link_fail_i),
    .pkt_nxt_o   (pkt_nxt),
    .crs_o       (crs_o)
  );

  mii_rx_valid #(.DATA_W(DATA_W)) u_valid (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_nxt_i   (pkt_nxt),
    .speed_100_i (speed_100_i),
    .clk_rec_i   (clk_rec_i),
    .nib_i       (nib_i),
    .err_i       (err_i),
    .rxdv_o      (rxdv_o),
    .rxd_o       (rxd_o),
    .rxer_o      (rxer_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_o <= 1'b0;
    else         col_o <= col_det_i;
  end
endmodule

// File: rtl/mii_rx_seq_chk.sv
module mii_rx_seq_chk #(
  parameter int unsigned DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sop_i,
  input logic              eop_i,
  input logic              err_i,
  input logic              link_fail_i,
  input logic              speed_100_i,
  input logic              col_det_i,
  input logic [DATA_W-1:0] rxd_o,
  input logic              crs_o,
  input logic              rxdv_o,
  input logic              rxer_o,
  input logic              col_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> (!crs_o && !rxdv_o && !rxer_o && !col_o) || rst_ni); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) !rxdv_o |-> rxd_o == '0); // R2
  AST_DV_IN_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni) rxdv_o |-> crs_o); // R3
  AST_START_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni) past_ok && $past(sop_i && !eop_i && !link_fail_i) |-> crs_o); // R3
  AST_END_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) past_ok && $past(eop_i) |-> !crs_o && !rxdv_o); // R5 R11
  AST_LINK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) past_ok && $past(link_fail_i) |-> !crs_o && !rxdv_o && rxd_o == '0); // R6
  AST_ERR_IN_DV: assert property (@(posedge clk_i) disable iff (!rst_ni) rxer_o |-> rxdv_o && past_ok && $past(err_i)); // R7
  AST_SLOW_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni) past_ok && !$past(speed_100_i) |-> !rxer_o); // R8
  AST_COL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) past_ok |-> col_o == $past(col_det_i)); // R10
endmodule

bind mii_rx_seq mii_rx_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sop_i       (sop_i),
  .eop_i       (eop_i),
  .err_i       (err_i),
  .link_fail_i (link_fail_i),
  .speed_100_i (speed_100_i),
  .col_det_i   (col_det_i),
  .rxd_o       (rxd_o),
  .crs_o       (crs_o),
  .rxdv_o      (rxdv_o),
  .rxer_o      (rxer_o),
  .col_o       (col_o)
);

// File: tb/mii_rx_seq_bench.sv
module mii_rx_seq_bench;
  localparam int unsigned DATA_W = 4;
  localparam time CLK_P = 10ns;
  localparam int unsigned N_RAND = 4000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] nib_i = '0;
  logic sop_i = 0, eop_i = 0, err_i = 0, link_fail_i = 0;
  logic speed_100_i = 1, clk_rec_i = 0, col_det_i = 0;
  logic [DATA_W-1:0] rxd_o;
  logic crs_o, rxdv_o, rxer_o, col_o;

  int checks = 0;
  int errors = 0;
  bit m_pkt = 0, m_dv = 0;
  bit e_crs, e_dv, e_er, e_col;
  logic [DATA_W-1:0] e_rxd;
  string t_crs, t_dv, t_er;

  always #(CLK_P/2) clk_i = ~clk_i;

  mii_rx_seq #(.DATA_W(DATA_W)) u_mii_rx_seq (.*);

  function automatic bit next_pkt(bit cur, bit sop, bit eop, bit lf);
    if (lf || eop) return 1'b0;
    if (sop) return 1'b1;
    return cur;
  endfunction

  function automatic bit next_dv(bit pkt_n, bit cur_dv, bit spd, bit rec);
    return pkt_n && (spd || rec || cur_dv);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // apply at negedge, predict, check at following negedge
  task automatic step(bit sop, bit eop, bit err, bit lf, bit spd, bit rec, bit col,
                      logic [DATA_W-1:0] nib);
    bit pn;
    sop_i = sop; eop_i = eop; err_i = err; link_fail_i = lf;
    speed_100_i = spd; clk_rec_i = rec; col_det_i = col; nib_i = nib;
    pn = next_pkt(m_pkt, sop, eop, lf);
    e_dv  = next_dv(pn, m_dv, spd, rec);
    e_crs = pn;
    e_rxd = e_dv ? nib : '0;
    e_er  = e_dv && spd && err;
    e_col = col;
    if (lf)              t_crs = "R6";
    else if (sop && eop) t_crs = "R11";
    else if (eop)        t_crs = "R5";
    else if (!pn)        t_crs = "R2";
    else                 t_crs = "R3";
    t_dv = (lf || eop || !pn) ? t_crs : (spd ? "R4" : "R9");
    t_er = spd ? "R7" : "R8";
    m_pkt = pn; m_dv = e_dv;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(crs_o == e_crs, t_crs, "crs", crs_o, e_crs);
    chk(rxdv_o == e_dv, t_dv, "rxdv", rxdv_o, e_dv);
    chk(rxd_o == e_rxd, t_dv, "rxd", rxd_o, e_rxd);
    chk(rxer_o == e_er, t_er, "rxer", rxer_o, e_er);
    chk(col_o == e_col, "R10", "col", col_o, e_col);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0177));
    repeat (3) @(negedge clk_i);
    chk(crs_o == 0 && rxdv_o == 0, "R1", "crs|dv in reset", {crs_o, rxdv_o}, 0);
    chk(rxd_o == 0 && rxer_o == 0 && col_o == 0, "R1", "rxd|er|col in reset",
        {rxd_o, rxer_o, col_o}, 0);
    rst_ni = 1'b1;
    // R2 idle
    step(0,0,1,0,1,0,0,4'hF);
    // R3/R4 100M packet, R7 single error nibble, R5 end
    step(1,0,0,0,1,0,0,4'h5);
    step(0,0,1,0,1,0,0,4'hA);
    step(0,0,0,0,1,0,0,4'h3);
    step(0,1,0,0,1,0,0,4'h9);
    // R11 start and end together from idle, then inside packet
    step(1,1,0,0,1,0,0,4'h7);
    step(1,0,0,0,1,0,0,4'h1);
    step(1,1,0,0,1,0,0,4'h2);
    // R9 10M: valid waits for recovery, R8 no error
    step(1,0,1,0,0,0,0,4'hC);
    step(0,0,1,0,0,0,0,4'hD);
    step(0,0,1,0,0,1,0,4'hE);
    step(0,0,1,0,0,0,1,4'h6);
    step(0,1,0,0,0,0,0,4'h4);
    // R6 link fail in mid-packet and with start strobe
    step(1,0,0,0,1,0,0,4'h8);
    step(1,0,0,1,1,0,1,4'hB);
    step(0,0,0,1,1,0,0,4'hB);
    step(0,1,0,0,1,0,0,4'h0);
    for (int i = 0; i < N_RAND; i++) begin
      bit spd = (i / 500) % 2 == 0;
      step($urandom_range(0,9) == 0, $urandom_range(0,11) == 0,
           $urandom_range(0,5) == 0, $urandom_range(0,40) == 0,
           spd ^ ($urandom_range(0,60) == 0), $urandom_range(0,7) == 0,
           $urandom_range(0,15) == 0, DATA_W'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule